// File: doc/BRIEF.md
# Two-Wire Clock-High Toggle Event Detector

This block sits beside the pad of a two-wire debug port, where a single data/control line is shared in both directions and clocked by a slow scan clock. In ordinary serial signalling the line may change only while the scan clock is low. Control events are carried by breaking that rule on purpose. The block counts how many times the line toggles while the scan clock is high. On each falling scan-clock edge it turns that count into one of four outcomes: nothing, an escape, an extended escape, or a link reset.

Both pins are oversampled by a fast system clock through a configurable synchronizer, and edges are detected in that domain. The block also produces the line driver's output enable, which is active only while the scan clock is low. It captures one incoming data bit per scan-clock period, on the rising or the falling scan-clock edge as chosen by a configuration input. Pad cells and the protocol layers that act on the events belong to the surrounding design.

Top module: `tw_line_monitor`

## Requirements
- R1: While `rst_n` is low, `evt_escape`, `evt_ext`, `evt_link_reset`, `data_valid`, `data_bit` and `drive_en` are all 0. An event that would have been reported during reset is dropped.
- R2: In the default driver variant (`DRIVE_GUARD`=0), `drive_en` is 1 exactly when `scan_clk` is 0 and reset is released. It is 0 at any time `scan_clk` is 1.
- R3: A scan-clock high phase with zero or one line toggle produces no event pulse.
- R4: A high phase with two or three toggles produces one `evt_escape` pulse. The pulse is seen after the (`SYNC_STAGES`+1)-th system-clock rising edge following the falling edge of `scan_clk`, which is the third edge with the defaults.
- R5: A high phase with four or five toggles produces one `evt_ext` pulse, with the same latency as R4.
- R6: A high phase with six or more toggles produces one `evt_link_reset` pulse, with the same latency as R4. This holds even when the number of toggles is larger than the counter can hold, because the counter saturates and does not wrap.
- R7: Each event pulse lasts one system-clock cycle. At most one of the three event outputs is high in any cycle. No event pulse appears except in response to a scan-clock falling edge.
- R8: The toggle count is cleared on every scan-clock rising edge. Toggles made during a low phase, or during an earlier high phase, do not count toward the next classification.
- R9: With `sample_on_fall`=0, `data_bit` takes the line level seen at the rising scan-clock edge. With `sample_on_fall`=1, it takes the level seen at the falling edge. Each capture is marked by a one-cycle `data_valid` pulse, one per scan-clock period.
- R10: `data_bit` changes only in a cycle where `data_valid` is 1. It keeps its value while the line moves between captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_clk | input | 1 | Scan clock from the pad, asynchronous to `clk` |
| scan_line | input | 1 | Level received on the shared data/control line |
| sample_on_fall | input | 1 | 0: capture data on the rising scan-clock edge; 1: capture on the falling edge |
| drive_en | output | 1 | Output enable for the line driver (1 = drive, 0 = high impedance) |
| data_bit | output | 1 | Last captured line level |
| data_valid | output | 1 | One-cycle pulse marking a new `data_bit` |
| evt_escape | output | 1 | One-cycle pulse: 2 or 3 toggles in the last high phase |
| evt_ext | output | 1 | One-cycle pulse: 4 or 5 toggles in the last high phase |
| evt_link_reset | output | 1 | One-cycle pulse: 6 or more toggles in the last high phase |

## Verification
The properties assume that both pins change slowly compared with `clk`. Each scan-clock phase and each gap between line toggles must last longer than the synchronizer, so that no edge is lost and the two synchronized pins never move in the same cycle. The stimulus follows this. Every pin change is applied on a falling edge of `clk`, line toggles are two system cycles apart, and every toggle is placed at least four cycles after the rising scan-clock edge and well before the falling one. Reset is released only while the scan clock is low, so no false rising edge is seen on exit from reset.

// File: rtl/tw_esc_pkg.sv
package tw_esc_pkg;

   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_ESC  = 2'd1,
      EV_EXT  = 2'd2,
      EV_LRST = 2'd3
   } tw_event_e;

   // Map a toggle count onto an event class using three ascending thresholds.
   function automatic tw_event_e tw_classify(input int unsigned n,
                                             input int unsigned esc_lo,
                                             input int unsigned ext_lo,
                                             input int unsigned rst_lo);
      if (n >= rst_lo)      return EV_LRST;
      else if (n >= ext_lo) return EV_EXT;
      else if (n >= esc_lo) return EV_ESC;
      else                  return EV_NONE;
   endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr[0] <= 1'b0;
      else        sr[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr[i] <= 1'b0;
         else        sr[i] <= sr[i-1];
      end
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/tw_toggle_count.sv
module tw_toggle_count #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             hi,
   input  logic             tog,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt <= '0;
      else if (clr)                       cnt <= '0;
      else if (hi && tog && cnt != CNT_MAX) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tw_event_gen.sv
module tw_event_gen
   import tw_esc_pkg::*;
#(
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned ESC_LO = 2,
   parameter int unsigned EXT_LO = 4,
   parameter int unsigned RST_LO = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic [CNT_W-1:0] cnt,
   output logic             evt_escape,
   output logic             evt_ext,
   output logic             evt_link_reset
);
   tw_event_e cls;

   always_comb cls = tw_classify(int'(cnt), ESC_LO, EXT_LO, RST_LO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_escape     <= 1'b0;
         evt_ext        <= 1'b0;
         evt_link_reset <= 1'b0;
      end else begin
         evt_escape     <= fire && (cls == EV_ESC);
         evt_ext        <= fire && (cls == EV_EXT);
         evt_link_reset <= fire && (cls == EV_LRST);
      end
   end
endmodule

// File: rtl/tw_line_monitor.sv
module tw_line_monitor #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned ESC_LO      = 2,
   parameter int unsigned EXT_LO      = 4,
   parameter int unsigned RST_LO      = 6,
   parameter bit          DRIVE_GUARD = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scan_clk,
   input  logic scan_line,
   input  logic sample_on_fall,
   output logic drive_en,
   output logic data_bit,
   output logic data_valid,
   output logic evt_escape,
   output logic evt_ext,
   output logic evt_link_reset
);
   localparam int unsigned CNT_TOP = (1 << CNT_W) - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tw_line_monitor: SYNC_STAGES must be at least 2");
   end
   if (!(ESC_LO > 0 && ESC_LO < EXT_LO && EXT_LO < RST_LO && RST_LO < CNT_TOP)) begin : g_bad_thr
      $error("tw_line_monitor: thresholds must ascend and fit below the counter ceiling");
   end

   logic ck_s, ck_d, ln_s, ln_d;
   logic ck_rise, ck_fall, ln_tog, take;
   logic [CNT_W-1:0] cnt;

   tw_sync #(.STAGES(SYNC_STAGES)) i_sync_ck (
      .clk(clk), .rst_n(rst_n), .d(scan_clk), .q(ck_s));
   tw_sync #(.STAGES(SYNC_STAGES)) i_sync_ln (
      .clk(clk), .rst_n(rst_n), .d(scan_line), .q(ln_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_d <= 1'b0;
         ln_d <= 1'b0;
      end else begin
         ck_d <= ck_s;
         ln_d <= ln_s;
      end
   end

   assign ck_rise = ck_s & ~ck_d;
   assign ck_fall = ~ck_s & ck_d;
   assign ln_tog  = ln_s ^ ln_d;

   tw_toggle_count #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .clr(ck_rise), .hi(ck_s), .tog(ln_tog), .cnt(cnt));

   tw_event_gen #(.CNT_W(CNT_W), .ESC_LO(ESC_LO), .EXT_LO(EXT_LO), .RST_LO(RST_LO)) i_evt (
      .clk(clk), .rst_n(rst_n), .fire(ck_fall), .cnt(cnt),
      .evt_escape(evt_escape), .evt_ext(evt_ext), .evt_link_reset(evt_link_reset));

   // Data capture on the selected scan-clock edge.
   assign take = sample_on_fall ? ck_fall : ck_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_valid <= 1'b0;
         data_bit   <= 1'b0;
      end else begin
         data_valid <= take;
         if (take) data_bit <= ln_s;
      end
   end

   // Driver enable: variant chosen by DRIVE_GUARD.
   if (DRIVE_GUARD) begin : g_drive_guard
      logic low_ok;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) low_ok <= 1'b0;
         else        low_ok <= ~ck_s & ~ck_d;
      end
      assign drive_en = low_ok & ~scan_clk;
   end else begin : g_drive_direct
      assign drive_en = rst_n & ~scan_clk;
   end
endmodule

// File: rtl/tw_line_monitor_chk.sv
module tw_line_monitor_chk (
   input logic clk,
   input logic rst_n,
   input logic scan_clk,
   input logic drive_en,
   input logic data_bit,
   input logic data_valid,
   input logic evt_escape,
   input logic evt_ext,
   input logic evt_link_reset
);
   logic any_evt;
   assign any_evt = evt_escape | evt_ext | evt_link_reset;

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!any_evt && !data_valid && !data_bit && !drive_en); // R1
      end
   end

   AST_HIZ_WHEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      scan_clk |-> !drive_en); // R2

   AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({evt_escape, evt_ext, evt_link_reset})); // R7

   AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      any_evt |=> !any_evt); // R7

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |=> !data_valid); // R9

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_bit) |-> data_valid); // R10
endmodule

bind tw_line_monitor tw_line_monitor_chk i_chk (
   .clk(clk), .rst_n(rst_n), .scan_clk(scan_clk), .drive_en(drive_en),
   .data_bit(data_bit), .data_valid(data_valid), .evt_escape(evt_escape),
   .evt_ext(evt_ext), .evt_link_reset(evt_link_reset));

// File: tb/test_tw_line_monitor.sv
`timescale 1ns/1ps
module test_tw_line_monitor;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scan_clk = 1'b0;
   logic scan_line = 1'b0;
   logic sample_on_fall = 1'b0;
   logic drive_en, data_bit, data_valid, evt_escape, evt_ext, evt_link_reset;

   always #10 clk = ~clk;

   tw_line_monitor i_tw_line_monitor (
      .clk(clk), .rst_n(rst_n), .scan_clk(scan_clk), .scan_line(scan_line),
      .sample_on_fall(sample_on_fall), .drive_en(drive_en), .data_bit(data_bit),
      .data_valid(data_valid), .evt_escape(evt_escape), .evt_ext(evt_ext),
      .evt_link_reset(evt_link_reset));

   int n_chk = 0, n_bad = 0;
   int cyc = 0, fall_cyc = 0;
   int p_esc, p_ext, p_rst, p_first, p_valid, p_hi_bad, p_lo_bad;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Advance to the next falling clk edge and record what the outputs show.
   task automatic step();
      @(negedge clk);
      cyc++;
      if (evt_escape) p_esc++;
      if (evt_ext) p_ext++;
      if (evt_link_reset) p_rst++;
      if ((evt_escape || evt_ext || evt_link_reset) && p_first < 0) p_first = cyc - fall_cyc;
      if (data_valid) p_valid++;
      if (scan_clk && drive_en) p_hi_bad++;
      if (!scan_clk && rst_n && !drive_en) p_lo_bad++;
   endtask

   task automatic clear_obs();
      p_esc = 0; p_ext = 0; p_rst = 0; p_first = -1; p_valid = 0; p_hi_bad = 0; p_lo_bad = 0;
   endtask

   // One scan-clock period: high phase with n toggles, then a low phase.
   task automatic run_phase(input int n);
      clear_obs();
      scan_clk = 1'b1;
      repeat (4) step();
      for (int i = 0; i < n; i++) begin
         scan_line = ~scan_line;
         step(); step();
      end
      repeat (44 - 4 - 2*n) step();
      scan_clk = 1'b0;
      fall_cyc = cyc;
      repeat (16) step();
   endtask

   task automatic toggle_low(input int n);
      for (int i = 0; i < n; i++) begin
         scan_line = ~scan_line;
         step(); step();
      end
   endtask

   task automatic t_reset();
      clear_obs();
      repeat (3) step();
      chk(!evt_escape && !evt_ext && !evt_link_reset, "R1 events in reset", 0, 0);
      chk(!data_valid && !data_bit, "R1 data in reset", int'(data_bit), 0);
      chk(drive_en == 1'b0, "R1 drive_en in reset", int'(drive_en), 0);
      rst_n = 1'b1;
      repeat (4) step();
      chk(drive_en == 1'b1, "R2 drive_en low phase after reset", int'(drive_en), 1);
   endtask

   task automatic t_classes();
      int tog_list[10] = '{0, 1, 2, 3, 4, 5, 6, 7, 15, 17};
      foreach (tog_list[k]) begin
         int n = tog_list[k];
         int e_esc = (n == 2 || n == 3) ? 1 : 0;
         int e_ext = (n == 4 || n == 5) ? 1 : 0;
         int e_rst = (n >= 6) ? 1 : 0;
         run_phase(n);
         if (n < 2) chk(p_esc + p_ext + p_rst == 0, "R3 no event for 0/1 toggles", p_esc + p_ext + p_rst, 0);
         chk(p_esc == e_esc, "R4 escape pulse count", p_esc, e_esc);
         chk(p_ext == e_ext, "R5 extended escape pulse count", p_ext, e_ext);
         chk(p_rst == e_rst, "R6 link reset pulse count (saturating)", p_rst, e_rst);
         if (n >= 2) chk(p_first == 3, "R4 event latency in clk edges", p_first, 3);
         chk(p_hi_bad == 0, "R2 drive_en while scan_clk high", p_hi_bad, 0);
         chk(p_lo_bad == 0, "R2 drive_en while scan_clk low", p_lo_bad, 0);
      end
   endtask

   task automatic t_clear();
      // Toggles in the low phase must not count (R8).
      toggle_low(5);
      run_phase(1);
      chk(p_esc + p_ext + p_rst == 0, "R8 low-phase toggles ignored", p_esc + p_ext + p_rst, 0);
      // Count from an earlier high phase must not carry over (R8).
      run_phase(1);
      chk(p_esc + p_ext + p_rst == 0, "R8 count cleared each rising edge", p_esc + p_ext + p_rst, 0);
      run_phase(5);
      run_phase(1);
      chk(p_esc + p_ext + p_rst == 0, "R8 no carry after 5-toggle phase", p_esc + p_ext + p_rst, 0);
   endtask

   task automatic t_sample(input logic fall_mode);
      logic exp_bit;
      sample_on_fall = fall_mode;
      scan_line = 1'b1;
      repeat (4) step();
      run_phase(1); // line is 1 at rise, 0 at fall
      exp_bit = fall_mode ? 1'b0 : 1'b1;
      chk(p_valid == 1, "R9 one data_valid per period", p_valid, 1);
      chk(data_bit == exp_bit, "R9 captured level on selected edge", int'(data_bit), int'(exp_bit));
      toggle_low(3);
      chk(data_bit == exp_bit, "R10 data_bit held between captures", int'(data_bit), int'(exp_bit));
   endtask

   task automatic t_reset_mid();
      clear_obs();
      scan_clk = 1'b1;
      repeat (4) step();
      for (int i = 0; i < 6; i++) begin
         scan_line = ~scan_line;
         step(); step();
      end
      rst_n = 1'b0;
      step();
      scan_clk = 1'b0;
      fall_cyc = cyc;
      repeat (6) step();
      chk(p_esc + p_ext + p_rst == 0, "R1 event suppressed by reset", p_esc + p_ext + p_rst, 0);
      chk(drive_en == 1'b0, "R1 drive_en off in reset", int'(drive_en), 0);
      rst_n = 1'b1;
      repeat (6) step();
      run_phase(0);
      chk(p_esc + p_ext + p_rst == 0, "R1 no stale event after reset", p_esc + p_ext + p_rst, 0);
   endtask

   initial begin
      t_reset();
      t_classes();
      t_clear();
      t_sample(1'b0);
      t_sample(1'b1);
      t_reset_mid();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule